// File: doc/BRIEF.md
# ECC Error Capture and Status Register

This block sits beside the SECDED checker on the read path of an SDRAM controller. Every read that the checker flags arrives as a one-cycle pulse: a corrected (single-bit) error or an uncorrectable (multi-bit) error. The pulse comes with the 32-bit physical address of the read and the 8-bit syndrome. The block latches the first such event into a 32-bit status word that software reads. Software releases the word by writing ones to the status flags.

Capture is first-error-only. Once either status flag is set, the logged address and syndrome stay frozen until software clears the flag. A flag that reads 0 while the other reads 1 therefore means one of two things: that error type never happened, or it happened after the logged one. Two level outputs report a logged error. One is an NMI-style interrupt for corrected errors and the other is a system-error line for uncorrectable errors. Each output has its own enable bit. A control bit decides whether each corrected read also produces a one-cycle scrub request, which asks the controller to write the corrected data back.

The software-visible layout is fixed. Bit 31 is the scrub-disable bit (read/write). Bits 30:12 hold address bits 31:13 (read-only). Bits 11:4 hold the syndrome (read-only). Bit 3 is the system-error enable and bit 2 is the interrupt enable. Bit 1 is the multi-bit flag and bit 0 is the single-bit flag; both flags are write-one-to-clear.

Top module: `ecc_err_log`

## Requirements
- R1: After a synchronous reset, the status word reads 0x00000000 and `nmi_o`, `serr_o` and `scrub_req_o` are low.
- R2: A single-bit error pulse that arrives while both flags are clear is visible one clock later. It sets bit 0, loads `err_addr_i[31:13]` into bits 30:12 and loads `err_syn_i` into bits 11:4.
- R3: A multi-bit error pulse that arrives while both flags are clear sets bit 1 and loads the address and syndrome in the same way.
- R4: When single-bit and multi-bit pulses arrive in the same cycle with both flags clear, only bit 1 is set.
- R5: While bit 0 or bit 1 is set, further error pulses leave the address field, the syndrome field and both flags unchanged.
- R6: A write sets no status flag. A write with bit 0 or bit 1 at 1 clears that flag, and a 0 in that position leaves the flag as it is. After both flags are clear, the next error is captured again.
- R7: Writes have no effect on bits 30:4.
- R8: Bits 31, 3 and 2 take the written value on every write and read it back.
- R9: `nmi_o` is a level that equals bit 0 AND bit 2. It follows the status word in the same cycle.
- R10: `serr_o` is a level that equals bit 1 AND bit 3. It follows the status word in the same cycle.
- R11: Each single-bit pulse that has no multi-bit pulse in the same cycle, arriving while bit 31 is 0, makes `scrub_req_o` high for exactly one cycle, one clock later. In that cycle `scrub_addr_o` carries the full address of that read. This happens whether or not the status word is locked. No scrub request occurs for multi-bit errors or while bit 31 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_sbe_i | input | 1 | Corrected-error pulse from the ECC checker |
| err_mbe_i | input | 1 | Uncorrectable-error pulse from the ECC checker |
| err_addr_i | input | 32 | Physical address of the flagged read |
| err_syn_i | input | 8 | Syndrome of the flagged read |
| wr_en_i | input | 1 | Software write strobe for the status word |
| wr_data_i | input | 32 | Software write data |
| rd_data_o | output | 32 | Current status word |
| nmi_o | output | 1 | Interrupt level for a logged corrected error |
| serr_o | output | 1 | System-error level for a logged uncorrectable error |
| scrub_req_o | output | 1 | One-cycle scrub write-back request |
| scrub_addr_o | output | 32 | Address to scrub, valid with the request |

## Verification
A lock that fails to hold shows up as a changed address or syndrome field on the read port. A flag of the wrong type shows up as the wrong bit pair in the status word. Both are visible at the first sample after the offending pulse, because every field is one register deep. A broken enable or clear path shows up the same way, as a stuck or missing level on `nmi_o` or `serr_o`. The sweeps use every syndrome value and varied address patterns. As a result, a swapped or shifted field bit differs from the arithmetic expectation within one capture.

// File: rtl/ecc_err_log_pkg.sv
package ecc_err_log_pkg;

  // Software-visible control bits.
  typedef struct packed {
    logic scrub_off;
    logic serr_en;
    logic nmi_en;
  } ctl_t;

  // Sticky status flags.
  typedef struct packed {
    logic mbe;
    logic sbe;
  } flags_t;

  // Fixed positions of the low control/status bits.
  localparam int unsigned BIT_SBE     = 0;
  localparam int unsigned BIT_MBE     = 1;
  localparam int unsigned BIT_NMI_EN  = 2;
  localparam int unsigned BIT_SERR_EN = 3;
  localparam int unsigned LOW_BITS    = 4;

endpackage

// File: rtl/eclog_ctl.sv
module eclog_ctl
  import ecc_err_log_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en_i,
  input  ctl_t wr_ctl_i,
  output ctl_t ctl_o,
  output ctl_t ctl_nxt_o
);

  ctl_t ctl_q;

  always_comb begin
    ctl_nxt_o = ctl_q;
    if (wr_en_i) ctl_nxt_o = wr_ctl_i;
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_nxt_o;
  end

  assign ctl_o = ctl_q;

  // R8: the control bits change only on a write
  a_r8_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en_i |=> $stable(ctl_q));

endmodule

// File: rtl/eclog_capture.sv
module eclog_capture
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned KEEP_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SYN_W-1:0]  syn_i,
  input  flags_t            clr_i,
  output flags_t            flags_o,
  output flags_t            flags_nxt_o,
  output logic [KEEP_W-1:0] addr_o,
  output logic [SYN_W-1:0]  syn_o
);

  localparam int unsigned ADDR_LSB = ADDR_W - KEEP_W;

  flags_t            flags_q;
  logic [KEEP_W-1:0] addr_q;
  logic [SYN_W-1:0]  syn_q;
  logic              open;
  logic              take;

  assign open = ~(flags_q.sbe | flags_q.mbe);
  assign take = open & (sbe_i | mbe_i);

  always_comb begin
    flags_nxt_o = flags_q & ~clr_i;
    if (take) begin
      flags_nxt_o.mbe = mbe_i;
      flags_nxt_o.sbe = ~mbe_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      addr_q  <= '0;
      syn_q   <= '0;
    end else begin
      flags_q <= flags_nxt_o;
      if (take) begin
        addr_q <= addr_i[ADDR_W-1:ADDR_LSB];
        syn_q  <= syn_i;
      end
    end
  end

  assign flags_o = flags_q;
  assign addr_o  = addr_q;
  assign syn_o   = syn_q;

  // R5: a locked record keeps its address and syndrome
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    (flags_q.sbe || flags_q.mbe) |=> ($stable(addr_q) && $stable(syn_q)));

  // R4: never both flags at once
  a_r4_single_flag: assert property (@(posedge clk) disable iff (rst)
    !(flags_q.sbe && flags_q.mbe));

  // R3/R4: an uncorrectable pulse into an open record sets the multi-bit flag
  a_r3_mbe_taken: assert property (@(posedge clk) disable iff (rst)
    (mbe_i && !flags_q.sbe && !flags_q.mbe) |=> flags_q.mbe);

  // R5: a pulse cannot set a flag while the record is locked
  a_r5_no_new_flag: assert property (@(posedge clk) disable iff (rst)
    (flags_q.sbe && (sbe_i || mbe_i)) |=> !flags_q.mbe);

endmodule

// File: rtl/eclog_irq.sv
module eclog_irq
  import ecc_err_log_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  flags_t flags_nxt_i,
  input  ctl_t   ctl_nxt_i,
  output logic   nmi_o,
  output logic   serr_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_o  <= 1'b0;
      serr_o <= 1'b0;
    end else begin
      nmi_o  <= flags_nxt_i.sbe & ctl_nxt_i.nmi_en;
      serr_o <= flags_nxt_i.mbe & ctl_nxt_i.serr_en;
    end
  end

endmodule

// File: rtl/eclog_scrub.sv
module eclog_scrub #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sbe_i,
  input  logic              mbe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              scrub_off_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic fire;
  assign fire = sbe_i & ~mbe_i & ~scrub_off_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      req_o <= fire;
      if (fire) addr_o <= addr_i;
    end
  end

  // R11: a request always traces back to a corrected-only pulse with scrub on
  a_r11_scrub_cause: assert property (@(posedge clk) disable iff (rst)
    req_o |-> $past(sbe_i && !mbe_i && !scrub_off_i));

  // R11: no request follows an uncorrectable pulse
  a_r11_no_mbe_scrub: assert property (@(posedge clk) disable iff (rst)
    mbe_i |=> !req_o);

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_err_log_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SYN_W  = 8,
  parameter int unsigned KEEP_W = 19,
  parameter int unsigned REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_sbe_i,
  input  logic              err_mbe_i,
  input  logic [ADDR_W-1:0] err_addr_i,
  input  logic [SYN_W-1:0]  err_syn_i,
  input  logic              wr_en_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic [REG_W-1:0]  rd_data_o,
  output logic              nmi_o,
  output logic              serr_o,
  output logic              scrub_req_o,
  output logic [ADDR_W-1:0] scrub_addr_o
);

  localparam int unsigned SYN_LSB   = LOW_BITS;
  localparam int unsigned ADDR_FLSB = SYN_LSB + SYN_W;
  localparam int unsigned BIT_SCRUB = ADDR_FLSB + KEEP_W;

  initial begin
    if (BIT_SCRUB != REG_W - 1) $error("ecc_err_log: field widths do not fill REG_W");
  end

  ctl_t              ctl, ctl_nxt, wr_ctl;
  flags_t            flags, flags_nxt, clr;
  logic [KEEP_W-1:0] cap_addr;
  logic [SYN_W-1:0]  cap_syn;

  assign wr_ctl.scrub_off = wr_data_i[BIT_SCRUB];
  assign wr_ctl.serr_en   = wr_data_i[BIT_SERR_EN];
  assign wr_ctl.nmi_en    = wr_data_i[BIT_NMI_EN];
  assign clr.sbe          = wr_en_i & wr_data_i[BIT_SBE];
  assign clr.mbe          = wr_en_i & wr_data_i[BIT_MBE];

  eclog_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .wr_ctl_i  (wr_ctl),
    .ctl_o     (ctl),
    .ctl_nxt_o (ctl_nxt)
  );

  eclog_capture #(
    .ADDR_W (ADDR_W),
    .SYN_W  (SYN_W),
    .KEEP_W (KEEP_W)
  ) u_capture (
    .clk         (clk),
    .rst         (rst),
    .sbe_i       (err_sbe_i),
    .mbe_i       (err_mbe_i),
    .addr_i      (err_addr_i),
    .syn_i       (err_syn_i),
    .clr_i       (clr),
    .flags_o     (flags),
    .flags_nxt_o (flags_nxt),
    .addr_o      (cap_addr),
    .syn_o       (cap_syn)
  );

  eclog_irq u_irq (
    .clk         (clk),
    .rst         (rst),
    .flags_nxt_i (flags_nxt),
    .ctl_nxt_i   (ctl_nxt),
    .nmi_o       (nmi_o),
    .serr_o      (serr_o)
  );

  eclog_scrub #(
    .ADDR_W (ADDR_W)
  ) u_scrub (
    .clk         (clk),
    .rst         (rst),
    .sbe_i       (err_sbe_i),
    .mbe_i       (err_mbe_i),
    .addr_i      (err_addr_i),
    .scrub_off_i (ctl.scrub_off),
    .req_o       (scrub_req_o),
    .addr_o      (scrub_addr_o)
  );

  always_comb begin
    rd_data_o                          = '0;
    rd_data_o[BIT_SCRUB]               = ctl.scrub_off;
    rd_data_o[BIT_SCRUB-1:ADDR_FLSB]   = cap_addr;
    rd_data_o[ADDR_FLSB-1:SYN_LSB]     = cap_syn;
    rd_data_o[BIT_SERR_EN]             = ctl.serr_en;
    rd_data_o[BIT_NMI_EN]              = ctl.nmi_en;
    rd_data_o[BIT_MBE]                 = flags.mbe;
    rd_data_o[BIT_SBE]                 = flags.sbe;
  end

  // R9: interrupt level tracks the logged corrected flag and its enable
  a_r9_nmi_level: assert property (@(posedge clk) disable iff (rst)
    nmi_o == (flags.sbe && ctl.nmi_en));

  // R10: system-error level tracks the logged uncorrectable flag and its enable
  a_r10_serr_level: assert property (@(posedge clk) disable iff (rst)
    serr_o == (flags.mbe && ctl.serr_en));

  // R7: read-only fields ignore a write while the record is locked
  a_r7_ro_fields: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (flags.sbe || flags.mbe) && !clr.sbe && !clr.mbe)
      |=> $stable(rd_data_o[BIT_SCRUB-1:SYN_LSB]));

endmodule

// File: tb/test_ecc_err_log.sv
module test_ecc_err_log;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        err_sbe_i = 1'b0, err_mbe_i = 1'b0;
  logic [31:0] err_addr_i = '0;
  logic [7:0]  err_syn_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o, scrub_addr_o;
  logic        nmi_o, serr_o, scrub_req_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ecc_err_log i_ecc_err_log (
    .clk(clk), .rst(rst),
    .err_sbe_i(err_sbe_i), .err_mbe_i(err_mbe_i),
    .err_addr_i(err_addr_i), .err_syn_i(err_syn_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .nmi_o(nmi_o), .serr_o(serr_o),
    .scrub_req_o(scrub_req_o), .scrub_addr_o(scrub_addr_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Expected status word built from the documented field positions.
  function automatic logic [31:0] word(input logic so, input logic [31:0] a,
                                       input logic [7:0] s, input logic se,
                                       input logic ne, input logic mf, input logic sf);
    return {so, a[31:13], s, se, ne, mf, sf};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk); wr_en_i = 1'b0; wr_data_i = '0;
  endtask

  task automatic err(input logic s, input logic m, input logic [31:0] a, input logic [7:0] y);
    @(negedge clk); err_sbe_i = s; err_mbe_i = m; err_addr_i = a; err_syn_i = y;
    @(negedge clk); err_sbe_i = 1'b0; err_mbe_i = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, a0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", rd_data_o, 32'h0);
    check("R1 reset levels", {29'd0, nmi_o, serr_o, scrub_req_o}, 32'h0);

    // R8: control bits read back
    wr(32'h8000_000C);
    check("R8 ctl readback set", rd_data_o, 32'h8000_000C);
    wr(32'h0000_0004);
    check("R8 ctl readback mix", rd_data_o, 32'h0000_0004);
    wr(32'h0000_000C);

    // R2 / R9 / R11 / R6: sweep every syndrome through a corrected error
    for (int s = 0; s < 256; s++) begin
      a = (s * 32'h0101_0101) ^ (32'h9E37_79B9 << (s % 7));
      err(1'b1, 1'b0, a, s[7:0]);
      check("R2 sbe capture", rd_data_o, word(1'b0, a, s[7:0], 1'b1, 1'b1, 1'b0, 1'b1));
      check("R9 nmi high", {31'd0, nmi_o}, 32'd1);
      check("R11 scrub req", {31'd0, scrub_req_o}, 32'd1);
      check("R11 scrub addr", scrub_addr_o, a);
      wr(32'h0000_000D);
      check("R6 sbe cleared", rd_data_o, word(1'b0, a, s[7:0], 1'b1, 1'b1, 1'b0, 1'b0));
      check("R9 nmi low", {31'd0, nmi_o}, 32'd0);
      check("R11 scrub one cycle", {31'd0, scrub_req_o}, 32'd0);
    end

    // R3 / R10: uncorrectable errors
    for (int k = 0; k < 32; k++) begin
      a = 32'h1 << k | 32'h0000_2000;
      err(1'b0, 1'b1, a, 8'(k * 37));
      check("R3 mbe capture", rd_data_o, word(1'b0, a, 8'(k * 37), 1'b1, 1'b1, 1'b1, 1'b0));
      check("R10 serr high", {31'd0, serr_o}, 32'd1);
      check("R11 no scrub on mbe", {31'd0, scrub_req_o}, 32'd0);
      wr(32'h0000_000E);
      check("R10 serr low", {31'd0, serr_o}, 32'd0);
    end

    // R4: both pulses together
    err(1'b1, 1'b1, 32'hDEAD_BEEF, 8'h5A);
    check("R4 mbe wins", rd_data_o, word(1'b0, 32'hDEAD_BEEF, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b0));
    check("R11 no scrub on both", {31'd0, scrub_req_o}, 32'd0);
    wr(32'h0000_000E);

    // R5: lock holds; scrub still runs for later corrected reads (R11)
    a0 = 32'hCAFE_0000;
    err(1'b1, 1'b0, a0, 8'h11);
    err(1'b0, 1'b1, 32'h1234_5678, 8'h22);
    check("R5 locked after mbe", rd_data_o, word(1'b0, a0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1));
    check("R5 serr stays low", {31'd0, serr_o}, 32'd0);
    err(1'b1, 1'b0, 32'h0BAD_F00D, 8'h33);
    check("R5 locked after sbe", rd_data_o, word(1'b0, a0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1));
    check("R11 scrub while locked", scrub_addr_o, 32'h0BAD_F00D);

    // R6: writing 0 to a flag keeps it; R7: read-only fields ignore writes
    wr(32'h7FFF_FFFC);
    check("R7 ro ignored R6 zero keeps", rd_data_o, word(1'b0, a0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1));
    wr(32'h0000_000F);
    err(1'b0, 1'b1, 32'hFFFF_E000, 8'hFF);
    check("R6 recapture", rd_data_o, word(1'b0, 32'hFFFF_E000, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0));
    wr(32'h0000_000E);

    // R11: scrub disabled
    wr(32'h8000_000C);
    err(1'b1, 1'b0, 32'h4444_4444, 8'h44);
    check("R11 scrub off", {31'd0, scrub_req_o}, 32'd0);
    check("R2 capture scrub off", rd_data_o, word(1'b1, 32'h4444_4444, 8'h44, 1'b1, 1'b1, 1'b0, 1'b1));
    wr(32'h8000_0001);
    check("R9 nmi gated by enable", {31'd0, nmi_o}, 32'd0);

    // R9 / R10: enable turned on while a flag is held
    err(1'b1, 1'b0, 32'h5555_0000, 8'h55);
    check("R9 nmi disabled", {31'd0, nmi_o}, 32'd0);
    wr(32'h0000_0004);
    check("R9 nmi after enable", {31'd0, nmi_o}, 32'd1);
    wr(32'h0000_0001);
    err(1'b0, 1'b1, 32'h6666_0000, 8'h66);
    check("R10 serr disabled", {31'd0, serr_o}, 32'd0);
    wr(32'h0000_0008);
    check("R10 serr after enable", {31'd0, serr_o}, 32'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule